// File: doc/BRIEF.md
# Dual-Register Configurable Logic Cell

This block is one output cell of a programmable logic array. It sits behind an AND-array and receives twelve product terms in three groups of four. An 8-bit configuration word, held static while the cell runs, decides three things. It decides how the groups are ORed into the data inputs of two flip-flops. It decides whether the pad is driven from the first flip-flop or straight from the sum logic, and with which polarity. It also decides whether the buried feedback returns the second flip-flop or that flip-flop's raw data input.

Each flip-flop can be a D or a T type. Each has its own clock term, clear term and data term. The cell runs on one system clock. A flip-flop's selected clock term is treated as a data signal, and the flip-flop updates in the system-clock cycle in which a rising edge of that term is seen. An output-enable term drives the pad enable. The pad's input is returned on a separate path, so the pad can be used in both directions. A security input hides the second flip-flop from outside observation and blocks preload.

Top module: `pm_macrocell`

## Requirements
- R1: Sum routing is set by configuration bits [1:0]. Groups A, B and C are product terms [3:0], [7:4] and [11:8], and each group is ORed into a sum. The first data input is A|B for codes 00 and 11, A alone for code 01, and A|B|C for code 10. The second data input is always C.
- R2: Configuration bit 2 selects the pad source. At 0 the pad is driven from flip-flop 1. At 1 it is driven from the first data input in the same cycle.
- R3: Configuration bit 3 sets the pad polarity. At 1 the selected value reaches the pad unchanged. At 0 it is inverted.
- R4: Configuration bits 4 and 5 set flip-flops 1 and 2 as D type (0) or T type (1). On an update, a D flip-flop loads its data input. A T flip-flop inverts its state when the data input is 1 and keeps its state otherwise.
- R5: Flip-flop 1 updates only in a cycle where its selected clock goes from 0 to 1, compared with the previous cycle. Its selected clock is clock term 0 when configuration bit 6 is 0, and clock term 0 AND the clock pin when bit 6 is 1. Flip-flop 2 works the same way with clock term 1 and bit 7.
- R6: When clear term n is 1 at a system-clock edge, flip-flop n becomes 0 at that edge. This takes priority over preload and over a clock update.
- R7: The buried feedback is flip-flop 2 for split codes 00, 01 and 10. For code 11 it is the second data input, in the same cycle. The flip-flop 1 feedback is always flip-flop 1.
- R8: The pad enable equals the output-enable term, and the pad-input feedback equals the pad input, in every mode.
- R9: When preload is requested and secure is 0, flip-flop n loads preload bit n, and this takes priority over a clock update. When secure is 1, preload has no effect and the observed flip-flop 2 value reads 0. The buried feedback is unchanged by secure.
- R10: A synchronous active-high reset clears both flip-flops and both clock-edge history bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 8 | Static configuration word |
| pt | input | 12 | Product terms, three groups of four |
| ck_term | input | 2 | Clock product term per flip-flop |
| clr_term | input | 2 | Clear product term per flip-flop |
| oe_term | input | 1 | Output-enable product term |
| pin_clk | input | 1 | Dedicated clock pin value |
| secure | input | 1 | Security setting |
| preload_en | input | 1 | Preload request |
| preload_val | input | 2 | Preload values for flip-flops 1 and 2 |
| pad_i | input | 1 | Value read from the pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| pad_fb | output | 1 | Pad input path back to the array |
| fb_q1 | output | 1 | Flip-flop 1 feedback |
| fb_buried | output | 1 | Flip-flop 2 or raw second data input feedback |
| q2_obs | output | 1 | Externally observed flip-flop 2 |

## Verification
A flip-flop result is due one system-clock edge after the edge that samples the rising clock term, the clear or the preload. Combinatorial pad values, the enable, the pad input path and the raw buried feedback are due in the same cycle as their inputs. The bench applies inputs just after each falling edge. Its reference model advances on each rising edge. All outputs are compared at the next falling edge, after the registered results have settled and before new inputs are applied.

// File: rtl/pm_cell_pkg.sv
package pm_cell_pkg;
  typedef struct packed {
    logic       r2_pinclk;
    logic       r1_pinclk;
    logic       r2_toggle;
    logic       r1_toggle;
    logic       pol_high;
    logic       comb_out;
    logic [1:0] split;
  } cell_cfg_t;

  localparam logic [1:0] SPLIT_8_4    = 2'b00;
  localparam logic [1:0] SPLIT_4_4    = 2'b01;
  localparam logic [1:0] SPLIT_12_4   = 2'b10;
  localparam logic [1:0] SPLIT_BURIED = 2'b11;
endpackage

// File: rtl/pm_sum_router.sv
module pm_sum_router #(
  parameter int PT_PER_SUM = 4,
  parameter int N_SUMS     = 3
) (
  input  logic [N_SUMS*PT_PER_SUM-1:0] pt,
  input  logic [1:0]                   split,
  output logic                         dt1,
  output logic                         dt2
);
  import pm_cell_pkg::*;

  logic [N_SUMS-1:0] sums;

  for (genvar g = 0; g < N_SUMS; g++) begin : g_sum
    assign sums[g] = |pt[g*PT_PER_SUM +: PT_PER_SUM];
  end

  always_comb begin
    unique case (split)
      SPLIT_4_4:  dt1 = sums[0];
      SPLIT_12_4: dt1 = sums[0] | sums[1] | sums[2];
      default:    dt1 = sums[0] | sums[1];
    endcase
    dt2 = sums[2];
  end
endmodule

// File: rtl/pm_dt_flop.sv
module pm_dt_flop (
  input  logic clk,
  input  logic rst,
  input  logic ck_term,
  input  logic pin_clk,
  input  logic use_pin,
  input  logic toggle,
  input  logic dt,
  input  logic clr,
  input  logic load_en,
  input  logic load_val,
  output logic q
);
  logic sel_clk;
  logic sel_prev;
  logic edge_seen;

  assign sel_clk   = ck_term & (use_pin ? pin_clk : 1'b1);
  assign edge_seen = sel_clk & ~sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= 1'b0;
      sel_prev <= 1'b0;
    end else begin
      sel_prev <= sel_clk;
      if (clr)            q <= 1'b0;
      else if (load_en)   q <= load_val;
      else if (edge_seen) q <= toggle ? (q ^ dt) : dt;
    end
  end
endmodule

// File: rtl/pm_macrocell.sv
module pm_macrocell #(
  parameter int PT_PER_SUM = 4,
  localparam int N_SUMS    = 3,
  localparam int N_PT      = N_SUMS * PT_PER_SUM,
  localparam int N_REG     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cfg,
  input  logic [N_PT-1:0]  pt,
  input  logic [N_REG-1:0] ck_term,
  input  logic [N_REG-1:0] clr_term,
  input  logic             oe_term,
  input  logic             pin_clk,
  input  logic             secure,
  input  logic             preload_en,
  input  logic [N_REG-1:0] preload_val,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             pad_fb,
  output logic             fb_q1,
  output logic             fb_buried,
  output logic             q2_obs
);
  import pm_cell_pkg::*;

  cell_cfg_t        c;
  logic             dt1, dt2;
  logic [N_REG-1:0] dt_vec, tog_vec, pin_vec, q_vec;
  logic             load_ok;
  logic             pick;

  assign c       = cell_cfg_t'(cfg);
  assign load_ok = preload_en & ~secure;

  pm_sum_router #(.PT_PER_SUM(PT_PER_SUM), .N_SUMS(N_SUMS)) u_route (
    .pt(pt), .split(c.split), .dt1(dt1), .dt2(dt2)
  );

  assign dt_vec  = {dt2, dt1};
  assign tog_vec = {c.r2_toggle, c.r1_toggle};
  assign pin_vec = {c.r2_pinclk, c.r1_pinclk};

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    pm_dt_flop u_ff (
      .clk(clk), .rst(rst),
      .ck_term(ck_term[r]), .pin_clk(pin_clk), .use_pin(pin_vec[r]),
      .toggle(tog_vec[r]), .dt(dt_vec[r]), .clr(clr_term[r]),
      .load_en(load_ok), .load_val(preload_val[r]), .q(q_vec[r])
    );
  end

  assign pick      = c.comb_out ? dt1 : q_vec[0];
  assign pad_o     = c.pol_high ? pick : ~pick;
  assign pad_oe    = oe_term;
  assign pad_fb    = pad_i;
  assign fb_q1     = q_vec[0];
  assign fb_buried = (c.split == SPLIT_BURIED) ? dt2 : q_vec[1];
  assign q2_obs    = secure ? 1'b0 : q_vec[1];
endmodule

// File: rtl/pm_macrocell_chk.sv
module pm_macrocell_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  cfg,
  input logic [11:0] pt,
  input logic [1:0]  ck_term,
  input logic [1:0]  clr_term,
  input logic        secure,
  input logic        preload_en,
  input logic        pad_o,
  input logic        fb_q1,
  input logic        fb_buried,
  input logic        q2_obs
);
  // R6: a clear term forces flip-flop 1 low at the next edge
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_term[0] |=> !fb_q1);

  // R5: no rising clock term, no clear, no preload -> flip-flop 1 holds
  a_r5_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
    (!ck_term[0] && !clr_term[0] && !(preload_en && !secure)) |=> $stable(fb_q1));

  // R9: secured cell never shows flip-flop 2
  a_r9_secure_hides: assert property (@(posedge clk) disable iff (rst)
    secure |-> !q2_obs);

  // R2: registered, active-high mode mirrors flip-flop 1 on the pad
  a_r2_reg_pad: assert property (@(posedge clk) disable iff (rst)
    (!cfg[2] && cfg[3]) |-> (pad_o == fb_q1));

  // R7: buried mode returns the raw group-C sum
  a_r7_buried_raw: assert property (@(posedge clk) disable iff (rst)
    (cfg[1:0] == 2'b11) |-> (fb_buried == (|pt[11:8])));
endmodule

bind pm_macrocell pm_macrocell_chk u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .pt(pt), .ck_term(ck_term),
  .clr_term(clr_term), .secure(secure), .preload_en(preload_en),
  .pad_o(pad_o), .fb_q1(fb_q1), .fb_buried(fb_buried), .q2_obs(q2_obs)
);

// File: tb/pm_macrocell_tb_top.sv
`timescale 1ns/1ps
module pm_macrocell_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  cfg;
  logic [11:0] pt;
  logic [1:0]  ck_term, clr_term, preload_val;
  logic        oe_term, pin_clk, secure, preload_en, pad_i;
  logic        pad_o, pad_oe, pad_fb, fb_q1, fb_buried, q2_obs;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit m_q1, m_q2, m_p1, m_p2;

  always #2.5 clk = ~clk;

  pm_macrocell dut_i (
    .clk(clk), .rst(rst), .cfg(cfg), .pt(pt), .ck_term(ck_term),
    .clr_term(clr_term), .oe_term(oe_term), .pin_clk(pin_clk),
    .secure(secure), .preload_en(preload_en), .preload_val(preload_val),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_fb(pad_fb),
    .fb_q1(fb_q1), .fb_buried(fb_buried), .q2_obs(q2_obs)
  );

  // R1 reference: number of groups feeding the first data input
  function automatic bit ref_dt1(input logic [7:0] c, input logic [11:0] p);
    int  groups;
    bit  acc = 0;
    case (c[1:0])
      2'b01:   groups = 1;
      2'b10:   groups = 3;
      default: groups = 2;
    endcase
    for (int g = 0; g < groups; g++)
      for (int b = 0; b < 4; b++) acc = acc | p[g*4+b];
    return acc;
  endfunction

  function automatic bit ref_dt2(input logic [11:0] p);
    return p[8] | p[9] | p[10] | p[11];
  endfunction

  always @(posedge clk) begin
    bit s1, s2, d1, d2;
    if (rst) begin
      m_q1 = 0; m_q2 = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      s1 = ck_term[0] && (!cfg[6] || pin_clk);
      s2 = ck_term[1] && (!cfg[7] || pin_clk);
      d1 = ref_dt1(cfg, pt);
      d2 = ref_dt2(pt);
      if (clr_term[0]) m_q1 = 0;
      else if (preload_en && !secure) m_q1 = preload_val[0];
      else if (s1 && !m_p1) m_q1 = cfg[4] ? !(m_q1 == d1) : d1;
      if (clr_term[1]) m_q2 = 0;
      else if (preload_en && !secure) m_q2 = preload_val[1];
      else if (s2 && !m_p2) m_q2 = cfg[5] ? !(m_q2 == d2) : d2;
      m_p1 = s1; m_p2 = s2;
    end
  end

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    bit v;
    v = cfg[2] ? ref_dt1(cfg, pt) : m_q1;
    chk({tag, " R2/R3"}, "pad_o", pad_o, cfg[3] ? v : !v);
    chk({tag, " R8"}, "pad_oe", pad_oe, oe_term);
    chk({tag, " R8"}, "pad_fb", pad_fb, pad_i);
    chk({tag, " R4/R5/R6"}, "fb_q1", fb_q1, m_q1);
    chk({tag, " R7"}, "fb_buried", fb_buried, (cfg[1:0] == 2'b11) ? ref_dt2(pt) : m_q2);
    chk({tag, " R9"}, "q2_obs", q2_obs, secure ? 1'b0 : m_q2);
  endtask

  task automatic drive_random(input int clr_odds, input int sec_mode);
    for (int b = 0; b < 12; b++) pt[b] = ($urandom % 5) == 0;
    ck_term     = 2'($urandom);
    pin_clk     = 1'($urandom);
    clr_term[0] = ($urandom % clr_odds) == 0;
    clr_term[1] = ($urandom % clr_odds) == 0;
    preload_en  = ($urandom % 12) == 0;
    preload_val = 2'($urandom);
    oe_term     = 1'($urandom);
    pad_i       = 1'($urandom);
    secure      = (sec_mode == 2) ? 1'($urandom) : 1'(sec_mode);
  endtask

  task automatic run_phase(input string tag, input logic [7:0] c, input int clr_odds,
                           input int sec_mode, input int cycles);
    @(negedge clk);
    cfg = c;
    drive_random(clr_odds, sec_mode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all(tag);
      drive_random(clr_odds, sec_mode);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg = 8'h08; pt = '0; ck_term = '0; clr_term = '0; oe_term = 0;
    pin_clk = 0; secure = 0; preload_en = 0; preload_val = '0; pad_i = 0;
    repeat (3) @(negedge clk);
    // R10: reset state with a clock term held high during reset
    ck_term = 2'b11; pt = '1;
    @(negedge clk);
    chk("R10 reset", "fb_q1", fb_q1, 1'b0);
    chk("R10 reset", "q2_obs", q2_obs, 1'b0);
    chk("R10 reset", "pad_o", pad_o, 1'b0);
    rst = 0;
    ck_term = 2'b00; pt = '0;

    run_phase("R1 R2 split 8/4 D high", 8'b0000_1000, 10, 0, 400);
    run_phase("R3 active low",          8'b0000_0000, 10, 0, 300);
    run_phase("R4 both T",              8'b0011_1000, 10, 0, 400);
    run_phase("R5 pin-gated clocks",    8'b1100_1000, 10, 0, 400);
    run_phase("R1 comb 4 terms",        8'b0000_1101, 10, 0, 300);
    run_phase("R1 comb 12 terms",       8'b0000_1110, 10, 0, 300);
    run_phase("R1 reg 12 terms T low",  8'b0001_0010, 10, 0, 300);
    run_phase("R7 buried comb",         8'b0000_1111, 10, 0, 300);
    run_phase("R7 buried reg T",        8'b1011_1011, 10, 0, 300);
    run_phase("R6 heavy clear",         8'b0011_1000, 2,  0, 300);
    run_phase("R9 secure on",           8'b0010_1000, 40, 1, 400);
    run_phase("R9 secure mixed",        8'b0000_1011, 40, 2, 400);

    // R10: mid-run reset returns to the cleared state
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0; clr_term = '0; preload_en = 0; ck_term = '0;
    chk("R10 mid reset", "fb_q1", fb_q1, 1'b0);
    chk("R10 mid reset", "q2_obs", q2_obs, secure ? 1'b0 : 1'b0);
    run_phase("R10 after reset", 8'b0000_1000, 10, 0, 100);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule